// File: doc/BRIEF.md
# Hall Period Speed Lock Detector

This block watches one Hall sensor line of a brushless motor and times each electrical period in system clock cycles. It reports the last completed period and decides whether the rotor speed is steady enough for the drive to switch from 120-degree to 180-degree commutation. The commutation tables, PWM generation and braking sit outside this block.

The lock flag needs three conditions. Each new period must be no longer than a configured maximum period, which is the same as a minimum speed. It must also lie within a shift-based tolerance of the period before it. After the first period that meets both conditions, a configured number of further periods must also meet them before the flag is raised. Any period that fails clears the flag at once. The mode select output follows the flag.

The Hall input is synchronized with two flops and timed from rising edge to rising edge. The configuration fields are captured only at those edges, so the comparison in progress is not affected when they change mid-period.

Top module: `hall_speed_lock`

## Requirements
- R1: After a synchronous active-high reset, `lock_o` is 0, `mode_180_o` is 0 (120-degree commutation) and `period_o` is 0.
- R2: `period_o` takes the number of clock cycles between two consecutive rising edges of the synchronized Hall input, and holds that value until the next rising edge.
- R3: The period counter saturates at all-ones (2^CNT_W-1) and never wraps. A period measured as all-ones always fails the speed test.
- R4: The first rising edge after reset only starts timing. The first completed period is stored as the reference. No lock decision is made until a second period has completed.
- R5: A period passes the speed test when it is not saturated and is less than or equal to `max_period_i`.
- R6: A period passes the tolerance test when |new - previous| <= previous >> (tol_code_i + 2). Code 0 allows a quarter of the previous period and code 7 allows 1/512 of it.
- R7: `lock_o` rises after qual_revs_i + 1 consecutive passing comparisons. With qual_revs_i = 0, the first passing comparison locks.
- R8: A comparison that fails the speed test or the tolerance test clears `lock_o` and restarts the count of qualifying periods from zero.
- R9: `mode_180_o` is 1 (180-degree commutation) exactly while `lock_o` is 1, and 0 (120-degree) otherwise.
- R10: `tol_code_i`, `max_period_i` and `qual_revs_i` take effect only through their values at a rising Hall edge. A change that is reverted before the next edge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_i | input | 1 | Asynchronous Hall sensor line |
| tol_code_i | input | 3 | Tolerance code; allowed drift is previous >> (code+2) |
| max_period_i | input | CNT_W | Longest period that still counts as fast enough |
| qual_revs_i | input | QUAL_W | Extra qualifying periods required before lock |
| lock_o | output | 1 | Speed lock flag |
| mode_180_o | output | 1 | 1 selects 180-degree, 0 selects 120-degree commutation |
| period_o | output | CNT_W | Last completed period in clock cycles |

## Verification
The Hall line is driven with steady runs of equal periods, which show exactly when lock rises for different qualifying counts. Drifts are placed just inside and just outside the shift tolerance to separate a correct bound from an off-by-one or a wrong shift amount. Periods equal to and one above the speed limit are used to test the inclusive compare, and an over-long period is used to test the saturation rule. A configuration change that is reverted before the next edge, and the first periods after reset, show that only edge-time values and complete periods count.

// File: rtl/hall_lock_pkg.sv
package hall_lock_pkg;

    // Tolerance shift for code 0: previous period divided by 4.
    localparam int TOL_BASE_SHIFT = 2;

    typedef enum logic [1:0] {
        V_NONE  = 2'd0,   // no new period this cycle
        V_PRIME = 2'd1,   // first period, stored as reference only
        V_PASS  = 2'd2,   // speed and tolerance both met
        V_FAIL  = 2'd3    // speed or tolerance missed
    } verdict_e;

    typedef enum logic {
        MODE_120 = 1'b0,
        MODE_180 = 1'b1
    } cmode_e;

endpackage

// File: rtl/hall_edge_sync.sv
module hall_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hall_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], hall_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;

    // A rising edge is a single-cycle event.
    assert_rise_single_R2: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/hall_period_meter.sv
module hall_period_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_i,
    output logic             valid_o,
    output logic [CNT_W-1:0] period_o
);
    localparam logic [CNT_W-1:0] CNT_SAT = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             started_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            started_q <= 1'b0;
            valid_o   <= 1'b0;
            period_o  <= '0;
        end else if (rise_i) begin
            cnt_q     <= CNT_W'(1);
            started_q <= 1'b1;
            valid_o   <= started_q;
            if (started_q) period_o <= cnt_q;
        end else begin
            valid_o <= 1'b0;
            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_SAT && !rise_i) |=> cnt_q == CNT_SAT);

    assert_period_held_R2: assert property (@(posedge clk) disable iff (rst)
        !rise_i |=> $stable(period_o));

    assert_first_edge_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (rise_i && !started_q) |=> !valid_o);

endmodule

// File: rtl/hall_lock_judge.sv
module hall_lock_judge
    import hall_lock_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int QUAL_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              meas_valid_i,
    input  logic [CNT_W-1:0]  meas_period_i,
    input  logic [2:0]        tol_code_i,
    input  logic [CNT_W-1:0]  max_period_i,
    input  logic [QUAL_W-1:0] qual_revs_i,
    output logic              lock_o
);
    localparam logic [CNT_W-1:0] CNT_SAT = '1;
    localparam int SH_W = 4;

    logic [CNT_W-1:0]  prev_q;
    logic              have_prev_q;
    logic [QUAL_W-1:0] qual_q;

    logic [CNT_W-1:0]  diff;
    logic [CNT_W-1:0]  allowed;
    logic [SH_W-1:0]   shamt;
    logic              speed_ok;
    logic              tol_ok;
    verdict_e          verdict;

    always_comb begin
        shamt    = {1'b0, tol_code_i} + SH_W'(TOL_BASE_SHIFT);
        allowed  = prev_q >> shamt;
        diff     = (meas_period_i >= prev_q) ? (meas_period_i - prev_q)
                                             : (prev_q - meas_period_i);
        speed_ok = (meas_period_i != CNT_SAT) && (meas_period_i <= max_period_i);
        tol_ok   = (diff <= allowed);
        if (!meas_valid_i)           verdict = V_NONE;
        else if (!have_prev_q)       verdict = V_PRIME;
        else if (speed_ok && tol_ok) verdict = V_PASS;
        else                         verdict = V_FAIL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
            qual_q      <= '0;
            lock_o      <= 1'b0;
        end else begin
            if (meas_valid_i) prev_q <= meas_period_i;
            unique case (verdict)
                V_PRIME: have_prev_q <= 1'b1;
                V_PASS: begin
                    if (qual_q >= qual_revs_i) lock_o <= 1'b1;
                    else                       qual_q <= qual_q + QUAL_W'(1);
                end
                V_FAIL: begin
                    lock_o <= 1'b0;
                    qual_q <= '0;
                end
                default: ;
            endcase
        end
    end

    assert_lock_on_new_period_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> $past(meas_valid_i));

    assert_slow_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (meas_valid_i && have_prev_q && meas_period_i > max_period_i) |=> (!lock_o && qual_q == '0));

    assert_no_lock_before_ref_R4: assert property (@(posedge clk) disable iff (rst)
        !have_prev_q |-> !lock_o);

    assert_qual_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        (meas_valid_i && have_prev_q) |=> (qual_q <= $past(qual_q) + QUAL_W'(1)));

endmodule

// File: rtl/hall_speed_lock.sv
module hall_speed_lock
    import hall_lock_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int QUAL_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hall_i,
    input  logic [2:0]        tol_code_i,
    input  logic [CNT_W-1:0]  max_period_i,
    input  logic [QUAL_W-1:0] qual_revs_i,
    output logic              lock_o,
    output logic              mode_180_o,
    output logic [CNT_W-1:0]  period_o
);
    logic              rise;
    logic              meas_valid;
    logic [2:0]        tol_q;
    logic [CNT_W-1:0]  max_q;
    logic [QUAL_W-1:0] qual_q;
    cmode_e            mode;

    hall_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .hall_i (hall_i),
        .rise_o (rise)
    );

    hall_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk      (clk),
        .rst      (rst),
        .rise_i   (rise),
        .valid_o  (meas_valid),
        .period_o (period_o)
    );

    // Configuration is captured on the edge that closes a period.
    always_ff @(posedge clk) begin
        if (rst) begin
            tol_q  <= '0;
            max_q  <= '0;
            qual_q <= '0;
        end else if (rise) begin
            tol_q  <= tol_code_i;
            max_q  <= max_period_i;
            qual_q <= qual_revs_i;
        end
    end

    hall_lock_judge #(.CNT_W(CNT_W), .QUAL_W(QUAL_W)) u_judge (
        .clk           (clk),
        .rst           (rst),
        .meas_valid_i  (meas_valid),
        .meas_period_i (period_o),
        .tol_code_i    (tol_q),
        .max_period_i  (max_q),
        .qual_revs_i   (qual_q),
        .lock_o        (lock_o)
    );

    assign mode       = lock_o ? MODE_180 : MODE_120;
    assign mode_180_o = (mode == MODE_180);

    assert_cfg_edge_only_R10: assert property (@(posedge clk) disable iff (rst)
        !rise |=> ($stable(tol_q) && $stable(max_q) && $stable(qual_q)));

    assert_lock_needs_period_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_180_o) |-> $past(meas_valid));

endmodule

// File: tb/tb_hall_speed_lock.sv
module tb_hall_speed_lock;
    localparam int CNT_W  = 10;
    localparam int QUAL_W = 4;
    localparam int SAT    = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              hall = 1'b0;
    logic [2:0]        tol_code = 3'd0;
    logic [CNT_W-1:0]  max_period = CNT_W'(1000);
    logic [QUAL_W-1:0] qual_revs = '0;
    logic              lock;
    logic              mode180;
    logic [CNT_W-1:0]  period;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Reference state, kept from the requirements.
    bit m_started, m_have_prev, m_lock;
    int m_prev, m_qual, m_period, last_p;

    always #5 clk = ~clk;

    hall_speed_lock #(.CNT_W(CNT_W), .QUAL_W(QUAL_W)) dut (
        .clk          (clk),
        .rst          (rst),
        .hall_i       (hall),
        .tol_code_i   (tol_code),
        .max_period_i (max_period),
        .qual_revs_i  (qual_revs),
        .lock_o       (lock),
        .mode_180_o   (mode180),
        .period_o     (period)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        hall = 1'b0;
        rst  = 1'b1;
        wait_neg(4);
        rst  = 1'b0;
        m_started = 0; m_have_prev = 0; m_lock = 0;
        m_prev = 0; m_qual = 0; m_period = 0; last_p = 0;
        wait_neg(2);
    endtask

    // Reference update at a rising edge, using configuration seen at that edge.
    task automatic model_edge();
        int meas, diff, allowed;
        bit ok;
        if (!m_started) begin
            m_started = 1;
            return;
        end
        meas = (last_p >= SAT) ? SAT : last_p;
        m_period = meas;
        if (!m_have_prev) begin
            m_have_prev = 1;
        end else begin
            diff    = (meas > m_prev) ? meas - m_prev : m_prev - meas;
            allowed = m_prev >> (int'(tol_code) + 2);
            ok = (meas != SAT) && (meas <= int'(max_period)) && (diff <= allowed);
            if (ok) begin
                if (m_qual >= int'(qual_revs)) m_lock = 1;
                else m_qual++;
            end else begin
                m_lock = 0;
                m_qual = 0;
            end
        end
        m_prev = meas;
    endtask

    // Raise hall (closing the previous period), check outputs, then finish a period of p cycles.
    task automatic step(input int p, input string req);
        hall = 1'b1;
        model_edge();
        wait_neg(8);
        check({req, " lock"}, int'(lock), int'(m_lock));
        check({req, " mode (R9)"}, int'(mode180), int'(m_lock));
        check({req, " period (R2)"}, int'(period), m_period);
        wait_neg(p / 2 - 8);
        hall = 1'b0;
        wait_neg(p - p / 2);
        last_p = p;
    endtask

    task automatic test_reset();
        do_reset();
        check("R1 lock", int'(lock), 0);
        check("R1 mode", int'(mode180), 0);
        check("R1 period", int'(period), 0);
    endtask

    task automatic test_first_periods();
        do_reset();
        qual_revs = '0; tol_code = 3'd0; max_period = CNT_W'(1000);
        step(100, "R4 first edge");
        check("R4 no period after first edge", int'(period), 0);
        step(100, "R4 reference period");
        check("R4 no lock on reference", int'(lock), 0);
        step(100, "R7 qual0 locks");
        check("R7 qual0 lock on first pass", int'(lock), 1);
    endtask

    task automatic test_qual_run();
        do_reset();
        qual_revs = QUAL_W'(2); tol_code = 3'd0; max_period = CNT_W'(1000);
        for (int i = 0; i < 4; i++) step(120, "R7 qual run");
        check("R7 not yet locked after two passes", int'(lock), 0);
        step(120, "R7 third pass");
        check("R7 locked after three passes", int'(lock), 1);
    endtask

    task automatic test_tolerance();
        do_reset();
        qual_revs = '0; tol_code = 3'd3; max_period = CNT_W'(1000);
        step(256, "R6 prime");
        step(256, "R6 ref");
        step(264, "R6 equal");
        step(272, "R6 +8 inside");       // 256>>5 = 8
        check("R6 lock at bound", int'(lock), 1);
        step(272, "R6 +8 inside 2");     // 272>>5 = 8, diff 8 -> pass
        step(272, "R6 over");
        check("R6 lock kept", int'(lock), 1);
        tol_code = 3'd5;                 // 272>>7 = 2
        step(275, "R6 code5");
        step(275, "R6 diff3 fails");
        check("R8 tolerance miss clears lock", int'(lock), 0);
        tol_code = 3'd0;
        step(275, "R6 recover");
        step(275, "R6 recovered");
        check("R6 relock", int'(lock), 1);
    endtask

    task automatic test_speed_limit();
        do_reset();
        qual_revs = '0; tol_code = 3'd0; max_period = CNT_W'(150);
        step(150, "R5 prime");
        step(150, "R5 ref");
        step(151, "R5 at limit");
        check("R5 period equal to limit locks", int'(lock), 1);
        step(151, "R5 over limit");
        check("R8 over limit clears lock", int'(lock), 0);
        step(150, "R5 back");
        step(150, "R5 back2");
    endtask

    task automatic test_saturation();
        do_reset();
        qual_revs = '0; tol_code = 3'd0; max_period = CNT_W'(SAT);
        step(1200, "R3 prime");
        step(1200, "R3 ref");
        step(1200, "R3 sat");
        check("R3 saturated period", int'(period), SAT);
        check("R3 saturated never locks", int'(lock), 0);
        step(100, "R3 after");
    endtask

    task automatic test_cfg_glitch();
        do_reset();
        qual_revs = '0; tol_code = 3'd0; max_period = CNT_W'(1000);
        step(100, "R10 prime");
        step(100, "R10 ref");
        step(100, "R10 lock");
        hall = 1'b1;
        model_edge();
        wait_neg(20);
        max_period = CNT_W'(10);
        qual_revs  = QUAL_W'(9);
        wait_neg(20);
        max_period = CNT_W'(1000);
        qual_revs  = '0;
        wait_neg(10);
        hall = 1'b0;
        wait_neg(50);
        last_p = 100;
        step(100, "R10 glitch ignored");
        check("R10 lock kept after reverted change", int'(lock), 1);
    endtask

    initial begin
        wait_neg(2);
        test_reset();
        test_first_periods();
        test_qual_run();
        test_tolerance();
        test_speed_limit();
        test_saturation();
        test_cfg_glitch();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_neg(150000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule